// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block is the hardware consumer of a transmit descriptor ring that lives in system memory. Software fills 16-byte descriptors, then advances a tail index through a 32-bit register port. While the hardware head index differs from tail and transmission is enabled, the engine reads the descriptor at head and offers its buffer address, byte length and command bits on a frame-request interface. It holds that request until the framing logic returns a one-cycle done pulse.

After done, the engine writes a status word into the descriptor if the descriptor asked for it. It then advances head modulo the number of ring slots and latches interrupt causes. The ring holds at most one fewer descriptor than it has slots, because head equal to tail means empty. Framing, CRC, payload movement and upper address bits belong to other blocks.

Top module: `txr_engine`

## Requirements
- R1: After reset, head, tail, pending causes and the interrupt mask read as 0, and frm_valid, mem_req and irq are low.
- R2: No descriptor read is issued while head equals tail or while the enable bit (control bit 0) is clear.
- R3: The descriptor in slot `head` sits at byte address base + 16*head. Its word at +0 is the buffer address, and its word at +8 carries the length in bits [15:0] and the command byte in bits [31:24]. Command bit 0 means end of packet, bit 1 means insert FCS and bit 3 means report status. These three values appear on frm_addr, frm_len and frm_cmd.
- R4: frm_valid stays high until frm_done is seen. frm_pad mirrors the pad-short-frames bit, which is control bit 1.
- R5: A write of 0x00000001 (done flag in status bit 0) goes to byte +12 of the descriptor only when report status is set. Otherwise the descriptor in memory is left untouched.
- R6: After each descriptor, head advances by one and wraps to 0 at the slot count. The slot count is the ring length register in bytes divided by 16.
- R7: Cause bit 1 (queue empty) is set when the advanced head equals tail, and it is not set otherwise.
- R8: Cause bit 0 (written back) is set after each descriptor whose status was written back.
- R9: Reading the cause register returns the pending bits and clears them. A cause raised in the same cycle as the read stays pending.
- R10: irq is high exactly when a pending cause has its mask bit set. Writing to the mask-set offset ORs bits into the mask, and writing to the mask-clear offset removes them.
- R11: Clearing enable while a descriptor is in flight lets that descriptor complete, and no further descriptor is fetched.
- R12: Register byte offsets are: control 0x00, base 0x04, length 0x08, head 0x0C, tail 0x10, cause 0x14, mask-set 0x18, mask-clear 0x1C. The mask offsets read back the mask. Head is read-only, and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears cause on its offset) |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | Access is a status write |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 32 | Status write data |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access complete |
| frm_valid | output | 1 | Frame request presented |
| frm_addr | output | 32 | Buffer address of the frame |
| frm_len | output | 16 | Frame length in bytes |
| frm_cmd | output | 8 | Descriptor command byte |
| frm_pad | output | 1 | Pad short frames |
| frm_done | input | 1 | One-cycle pulse: frame consumed |
| irq | output | 1 | Masked interrupt request |

## Verification
The assertions assume a well-behaved producer. Tail is kept below the slot count and is never advanced onto head. mem_ack arrives only while mem_req is high, and frm_done arrives only while frm_valid is high. The stimulus respects these limits. The bench posts at most as many descriptors as the ring can hold. Its memory model acknowledges one cycle after a fresh request. The done pulse is driven only after frm_valid has been observed.

// File: rtl/txr_pkg.sv
package txr_pkg;
    localparam int DESC_SHIFT = 4;

    localparam logic [4:0] OFS_CTRL  = 5'h00;
    localparam logic [4:0] OFS_BASE  = 5'h04;
    localparam logic [4:0] OFS_LEN   = 5'h08;
    localparam logic [4:0] OFS_HEAD  = 5'h0C;
    localparam logic [4:0] OFS_TAIL  = 5'h10;
    localparam logic [4:0] OFS_CAUSE = 5'h14;
    localparam logic [4:0] OFS_MSET  = 5'h18;
    localparam logic [4:0] OFS_MCLR  = 5'h1C;

    localparam int CMD_RS       = 3;
    localparam int CAUSE_WDONE  = 0;
    localparam int CAUSE_QEMPTY = 1;
    localparam logic [31:0] STATUS_DONE_WORD = 32'h0000_0001;

    typedef enum logic [2:0] {
        S_IDLE, S_FADDR, S_FLEN, S_SEND, S_WBACK, S_STEP
    } seq_state_e;

    typedef struct packed {
        logic [31:0] addr;
        logic [15:0] len;
        logic [7:0]  cmd;
    } txr_desc_t;

    function automatic logic [31:0] ring_next(logic [31:0] idx, logic [31:0] cnt);
        return (idx + 32'd1 >= cnt) ? 32'd0 : idx + 32'd1;
    endfunction
endpackage

// File: rtl/txr_regs.sv
module txr_regs
    import txr_pkg::*;
#(
    parameter int IDX_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [4:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic [IDX_W-1:0] head,
    input  logic [1:0]       cause_set,
    output logic             enable,
    output logic             pad,
    output logic [31:0]      base,
    output logic [IDX_W-1:0] count,
    output logic [IDX_W-1:0] tail,
    output logic [1:0]       cause,
    output logic [1:0]       mask
);
    logic rd_clr;
    assign rd_clr = reg_rd && (reg_addr == OFS_CAUSE);

    always_ff @(posedge clk) begin
        if (rst) begin
            enable <= 1'b0;
            pad    <= 1'b0;
            base   <= '0;
            count  <= '0;
            tail   <= '0;
            mask   <= '0;
            cause  <= '0;
        end else begin
            cause <= (rd_clr ? 2'b00 : cause) | cause_set;
            if (reg_wr) begin
                case (reg_addr)
                    OFS_CTRL: begin
                        enable <= reg_wdata[0];
                        pad    <= reg_wdata[1];
                    end
                    OFS_BASE: base  <= reg_wdata;
                    OFS_LEN:  count <= reg_wdata[IDX_W+DESC_SHIFT-1:DESC_SHIFT];
                    OFS_TAIL: tail  <= reg_wdata[IDX_W-1:0];
                    OFS_MSET: mask  <= mask | reg_wdata[1:0];
                    OFS_MCLR: mask  <= mask & ~reg_wdata[1:0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (reg_addr)
            OFS_CTRL:  reg_rdata = {30'b0, pad, enable};
            OFS_BASE:  reg_rdata = base;
            OFS_LEN:   reg_rdata = 32'({count, {DESC_SHIFT{1'b0}}});
            OFS_HEAD:  reg_rdata = 32'(head);
            OFS_TAIL:  reg_rdata = 32'(tail);
            OFS_CAUSE: reg_rdata = {30'b0, cause};
            OFS_MSET,
            OFS_MCLR:  reg_rdata = {30'b0, mask};
            default:   reg_rdata = 32'b0;
        endcase
    end

    // R9: a read with nothing new arriving leaves no cause pending
    a_r9_read_clears: assert property (@(posedge clk) disable iff (rst)
        (rd_clr && cause_set == 2'b00) |=> cause == 2'b00);
    // R9: a newly raised cause is never lost, even under a clearing read
    a_r9_set_sticks: assert property (@(posedge clk) disable iff (rst)
        (cause_set != 2'b00) |=> ((cause & $past(cause_set)) == $past(cause_set)));
endmodule

// File: rtl/txr_seq.sv
module txr_seq
    import txr_pkg::*;
#(
    parameter int IDX_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic [31:0]      base,
    input  logic [IDX_W-1:0] count,
    input  logic [IDX_W-1:0] tail,
    output logic             mem_req,
    output logic             mem_we,
    output logic [31:0]      mem_addr,
    output logic [31:0]      mem_wdata,
    input  logic [31:0]      mem_rdata,
    input  logic             mem_ack,
    output logic             frm_valid,
    output txr_desc_t        frm_desc,
    input  logic             frm_done,
    output logic [IDX_W-1:0] head,
    output logic [1:0]       cause_set
);
    seq_state_e       state;
    txr_desc_t        desc;
    logic [IDX_W-1:0] head_nxt;
    logic [31:0]      slot;
    logic             want_wb;

    assign head_nxt = IDX_W'(ring_next(32'(head), 32'(count)));
    assign slot     = base + (32'(head) << DESC_SHIFT);
    assign want_wb  = desc.cmd[CMD_RS];

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
            head  <= '0;
            desc  <= '0;
        end else begin
            case (state)
                S_IDLE:  if (enable && head != tail) state <= S_FADDR;
                S_FADDR: if (mem_ack) begin
                    desc.addr <= mem_rdata;
                    state     <= S_FLEN;
                end
                S_FLEN:  if (mem_ack) begin
                    desc.len <= mem_rdata[15:0];
                    desc.cmd <= mem_rdata[31:24];
                    state    <= S_SEND;
                end
                S_SEND:  if (frm_done) state <= want_wb ? S_WBACK : S_STEP;
                S_WBACK: if (mem_ack) state <= S_STEP;
                S_STEP: begin
                    head  <= head_nxt;
                    state <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_req   = (state == S_FADDR) || (state == S_FLEN) || (state == S_WBACK);
        mem_we    = (state == S_WBACK);
        mem_wdata = STATUS_DONE_WORD;
        case (state)
            S_FLEN:  mem_addr = slot + 32'd8;
            S_WBACK: mem_addr = slot + 32'd12;
            default: mem_addr = slot;
        endcase
        frm_valid = (state == S_SEND);
        frm_desc  = desc;
        cause_set = '0;
        if (state == S_STEP) begin
            cause_set[CAUSE_WDONE]  = want_wb;
            cause_set[CAUSE_QEMPTY] = (head_nxt == tail);
        end
    end

    // R4: a frame request is held until it is consumed
    a_r4_valid_hold: assert property (@(posedge clk) disable iff (rst)
        (frm_valid && !frm_done) |=> frm_valid);
    // R3: a pending memory access keeps its address
    a_r3_req_stable: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
    // R2 / R11: a new fetch starts only on a non-empty ring with enable set
    a_r2_fetch_gate: assert property (@(posedge clk) disable iff (rst)
        ($rose(mem_req) && !mem_we) |-> (head != tail && $past(enable)));
    // R5: status writes happen only for report-status descriptors
    a_r5_wb_only_rs: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> frm_desc.cmd[CMD_RS]);
    // R6: head only steps by one or wraps to zero
    a_r6_head_step: assert property (@(posedge clk) disable iff (rst)
        (head != $past(head)) |-> (head == $past(head) + 1'b1 || head == '0));
endmodule

// File: rtl/txr_engine.sv
module txr_engine
    import txr_pkg::*;
#(
    parameter int IDX_W = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [4:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic [31:0] mem_rdata,
    input  logic        mem_ack,
    output logic        frm_valid,
    output logic [31:0] frm_addr,
    output logic [15:0] frm_len,
    output logic [7:0]  frm_cmd,
    output logic        frm_pad,
    input  logic        frm_done,
    output logic        irq
);
    logic             enable, pad;
    logic [31:0]      base;
    logic [IDX_W-1:0] count, tail, head;
    logic [1:0]       cause, mask, cause_set;
    txr_desc_t        frm_desc;

    txr_regs #(.IDX_W(IDX_W)) u_regs (
        .clk(clk), .rst(rst),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .head(head), .cause_set(cause_set),
        .enable(enable), .pad(pad), .base(base), .count(count),
        .tail(tail), .cause(cause), .mask(mask)
    );

    txr_seq #(.IDX_W(IDX_W)) u_seq (
        .clk(clk), .rst(rst),
        .enable(enable), .base(base), .count(count), .tail(tail),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .frm_valid(frm_valid), .frm_desc(frm_desc), .frm_done(frm_done),
        .head(head), .cause_set(cause_set)
    );

    assign frm_addr = frm_desc.addr;
    assign frm_len  = frm_desc.len;
    assign frm_cmd  = frm_desc.cmd;
    assign frm_pad  = pad;
    assign irq      = |(cause & mask);
endmodule

// File: tb/sim_txr_engine.sv
module sim_txr_engine;
    localparam logic [4:0] A_CTRL = 5'h00, A_BASE = 5'h04, A_LEN = 5'h08, A_HEAD = 5'h0C,
                           A_TAIL = 5'h10, A_CAUSE = 5'h14, A_MSET = 5'h18, A_MCLR = 5'h1C;
    localparam int SLOTS = 4;
    localparam int RING_WORD = 32;     // base 0x80
    // {buffer address, length, command}
    localparam logic [55:0] VEC [6] = '{
        {32'h1000_0000, 16'd60,   8'h0B},
        {32'h2000_0040, 16'd1514, 8'h03},
        {32'hABCD_0010, 16'd64,   8'h09},
        {32'h0000_0100, 16'd128,  8'h01},
        {32'h5555_AAAA, 16'd9000, 8'h0B},
        {32'hFFFF_FFF0, 16'd1,    8'h02}
    };

    logic clk = 0, rst = 1;
    logic reg_wr = 0, reg_rd = 0;
    logic [4:0] reg_addr = 0;
    logic [31:0] reg_wdata = 0, reg_rdata;
    logic mem_req, mem_we, mem_ack = 0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata = 0;
    logic frm_valid, frm_pad, frm_done = 0, irq;
    logic [31:0] frm_addr;
    logic [15:0] frm_len;
    logic [7:0]  frm_cmd;
    logic [31:0] mem [64];
    int total = 0, bad = 0;

    always #5 clk = ~clk;

    txr_engine u0 (.*);

    initial begin
        forever begin
            @(posedge clk);
            mem_ack <= 1'b0;
            if (mem_req && !mem_ack) begin
                mem_ack <= 1'b1;
                if (mem_we) mem[mem_addr[7:2]] <= mem_wdata;
                else        mem_rdata <= mem[mem_addr[7:2]];
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk); reg_rd = 1; reg_addr = a; #1 d = reg_rdata;
        @(negedge clk); reg_rd = 0;
    endtask

    task automatic post(input int slot, input logic [55:0] v);
        mem[RING_WORD + 4*slot]     = v[55:24];
        mem[RING_WORD + 4*slot + 1] = 32'h0;
        mem[RING_WORD + 4*slot + 2] = {v[7:0], 8'h00, v[23:8]};
        mem[RING_WORD + 4*slot + 3] = 32'hEE;
    endtask

    task automatic wait_valid(output bit got);
        got = 0;
        for (int k = 0; k < 100 && !got; k++) begin
            @(negedge clk);
            got = frm_valid;
        end
    endtask

    task automatic pulse_done();
        @(negedge clk); frm_done = 1;
        @(negedge clk); frm_done = 0;
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #1_000_000;
        total++; bad++;
        $display("FAIL watchdog expired act=0 exp=1");
        finish_run();
    end

    initial begin
        logic [31:0] r;
        bit got;
        int seen;
        for (int k = 0; k < 64; k++) mem[k] = 32'h0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;

        // R1 reset state
        #1;
        check(!frm_valid && !mem_req && !irq, "R1 outputs idle", {frm_valid, mem_req, irq}, 0);
        rd(A_HEAD, r);  check(r == 0, "R1 head", r, 0);
        rd(A_TAIL, r);  check(r == 0, "R1 tail", r, 0);
        rd(A_CAUSE, r); check(r == 0, "R1 cause", r, 0);
        rd(A_MSET, r);  check(r == 0, "R1 mask", r, 0);

        // R12 head is read-only
        wr(A_HEAD, 32'h5);
        rd(A_HEAD, r); check(r == 0, "R12 head write ignored", r, 0);

        // R2 empty ring with enable: no fetch
        wr(A_BASE, 32'h80);
        wr(A_LEN, 32'd64);
        rd(A_LEN, r); check(r == 64, "R12 length readback", r, 64);
        wr(A_CTRL, 32'h1);
        seen = 0;
        for (int k = 0; k < 20; k++) begin @(negedge clk); if (mem_req) seen++; end
        check(seen == 0, "R2 empty ring idles", seen, 0);

        // table walk: R3..R9 with wrap
        wr(A_CTRL, 32'h3);
        for (int i = 0; i < 6; i++) begin
            int t;
            logic rs;
            t  = i % SLOTS;
            rs = VEC[i][3];
            post(t, VEC[i]);
            wr(A_TAIL, 32'((t + 1) % SLOTS));
            wait_valid(got);
            check(got, "R3 frame request seen", got, 1);
            check(frm_addr == VEC[i][55:24], "R3 frame address", frm_addr, VEC[i][55:24]);
            check(frm_len == VEC[i][23:8], "R3 frame length", frm_len, VEC[i][23:8]);
            check(frm_cmd == VEC[i][7:0], "R3 frame command", frm_cmd, VEC[i][7:0]);
            check(frm_pad == 1'b1, "R4 pad mirrored", frm_pad, 1);
            repeat (3) @(negedge clk);
            check(frm_valid, "R4 request held", frm_valid, 1);
            pulse_done();
            repeat (10) @(negedge clk);
            check(mem[RING_WORD + 4*t + 3] == (rs ? 32'h1 : 32'hEE), "R5 status write-back",
                  mem[RING_WORD + 4*t + 3], rs ? 32'h1 : 32'hEE);
            rd(A_HEAD, r);
            check(r == 32'((t + 1) % SLOTS), "R6 head advance/wrap", r, 32'((t + 1) % SLOTS));
            rd(A_CAUSE, r);
            check(r == {30'b0, 1'b1, rs}, "R7 R8 cause bits", r, {30'b0, 1'b1, rs});
            rd(A_CAUSE, r);
            check(r == 0, "R9 cause cleared by read", r, 0);
        end

        // R10 masking; head = tail = 2
        wr(A_MSET, 32'h1);
        post(2, {32'h0000_4000, 16'd70, 8'h0B});
        wr(A_TAIL, 32'd3);
        wait_valid(got);
        pulse_done();
        repeat (10) @(negedge clk);
        check(irq == 1'b1, "R10 irq on masked-in cause", irq, 1);
        wr(A_MCLR, 32'h1);
        #1 check(irq == 1'b0, "R10 irq off after mask clear", irq, 0);
        wr(A_MSET, 32'h2);
        #1 check(irq == 1'b1, "R10 irq from queue-empty", irq, 1);
        rd(A_CAUSE, r);
        check(r == 32'h3, "R9 pending kept while masked", r, 3);
        #1 check(irq == 1'b0, "R10 irq drops after read", irq, 0);

        // R11 disable mid-flight; head = tail = 3
        post(3, {32'h0000_5000, 16'd80, 8'h0B});
        post(0, {32'h0000_6000, 16'd90, 8'h0B});
        wr(A_TAIL, 32'd1);
        wait_valid(got);
        check(frm_addr == 32'h5000, "R11 first in flight", frm_addr, 32'h5000);
        wr(A_CTRL, 32'h0);
        check(frm_valid, "R11 in-flight kept", frm_valid, 1);
        pulse_done();
        seen = 0;
        for (int k = 0; k < 20; k++) begin @(negedge clk); if (frm_valid) seen++; end
        check(seen == 0, "R11 no fetch after disable", seen, 0);
        check(mem[RING_WORD + 15] == 32'h1, "R11 in-flight completed", mem[RING_WORD + 15], 1);
        rd(A_HEAD, r); check(r == 0, "R11 head wrapped", r, 0);
        rd(A_CAUSE, r); check(r == 32'h1, "R7 no queue-empty while pending", r, 1);
        wr(A_CTRL, 32'h1);
        wait_valid(got);
        check(got && frm_addr == 32'h6000, "R11 resumes on enable", frm_addr, 32'h6000);
        check(frm_pad == 1'b0, "R4 pad clear", frm_pad, 0);
        pulse_done();
        repeat (10) @(negedge clk);
        rd(A_HEAD, r); check(r == 1, "R6 head after resume", r, 1);

        // R2 disabled with pending descriptor
        wr(A_CTRL, 32'h0);
        post(1, {32'h0000_7000, 16'd10, 8'h01});
        wr(A_TAIL, 32'd2);
        seen = 0;
        for (int k = 0; k < 20; k++) begin @(negedge clk); if (mem_req) seen++; end
        check(seen == 0, "R2 disabled does not fetch", seen, 0);

        finish_run();
    end
endmodule